// File: doc/BRIEF.md
# Multi-Chain Fine-Time Averager

This block turns repeated fine-time readings of a single hit into one averaged fine time with more resolution. A hit is measured on a number of parallel delay chains at once, and each chain is read several times. An encoder in front of the block turns every reading into a binary fine code. Each measurement strobe presents one code per chain. The averager adds up all chains times readings codes for the hit and reports the mean in fixed point, keeping the fraction bits that the averaging creates.

A hit is opened by a one-cycle start pulse. The block then raises a busy flag and accepts strobes until it has seen the configured number of readings. It returns a one-cycle valid pulse with the result, and the result stays on the output until the next hit completes. The chain count and the readings per chain are parameters. More chains cost logic in the adder tree. More readings per chain lengthen the dead time of each hit. With the default of 8 chains and 4 readings per chain, each hit gives 32 samples.

Top module: `fine_time_averager`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` is 0, `avg_valid_o` is 0 and `avg_time_o` is 0.
- R2: A `hit_start_i` pulse while `busy_o` is 0 sets `busy_o` to 1 in the next cycle and clears the running sum and the reading count.
- R3: The sum of NUM_CHAINS×READS_PER_CHAIN codes never overflows. When every code is at its maximum (2^CODE_W−1), the result is exactly NUM_CHAINS×READS_PER_CHAIN×(2^CODE_W−1).
- R4: `avg_time_o` is unsigned fixed point. Its upper CODE_W bits are the integer part of the mean code, and its low log2(NUM_CHAINS×READS_PER_CHAIN) bits are the fraction. Its value therefore equals the sum of all codes of the hit. For example, with the defaults, chain i reporting code i on every strobe gives 112, which is a mean of 3.5.
- R5: In the cycle after the READS_PER_CHAIN-th accepted strobe, `avg_valid_o` is 1 for exactly one cycle and `busy_o` returns to 0 in that same cycle.
- R6: `hit_start_i` is ignored while `busy_o` is 1. It restarts neither the count nor the sum, and it does not delay the result.
- R7: `code_stb_i` is ignored while `busy_o` is 0. It changes neither `busy_o`, `avg_valid_o` nor `avg_time_o`.
- R8: `avg_time_o` holds its value in every cycle in which `avg_valid_o` is 0.
- R9: Accepted strobes need not be in consecutive cycles. Idle cycles between them do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_start_i | input | 1 | One-cycle pulse that opens a hit |
| code_stb_i | input | 1 | One reading per chain is present on `fine_codes_i` |
| fine_codes_i | input | NUM_CHAINS×CODE_W | Chain c's code occupies bits [c×CODE_W +: CODE_W] |
| busy_o | output | 1 | A hit is open and still collecting readings |
| avg_valid_o | output | 1 | One-cycle pulse: `avg_time_o` carries a new result |
| avg_time_o | output | CODE_W+log2(NUM_CHAINS×READS_PER_CHAIN) | Averaged fine time in fixed point |

## Verification
The bench runs four kinds of code sets, each against a cycle-by-cycle behavioural model. Codes set to their maximum expose any overflow of the accumulator. A code equal to the chain index gives a mean with a non-zero fraction, which shows whether the fraction bits are kept. A constant code gives a pure integer mean. Random codes catch lane swaps and missed terms that symmetric patterns hide. Gapped strobes, start pulses during a hit and strobes while idle separate the correct acceptance rules from a block that counts every strobe or restarts on every start pulse.

// File: rtl/fta_pkg.sv
package fta_pkg;

    // Number of bits needed to count up to `value` distinct states (at least 1).
    function automatic int unsigned bits_for(input int unsigned value);
        int unsigned w;
        w = 0;
        while ((32'd1 << w) < value) w++;
        return (w == 0) ? 1 : w;
    endfunction

    // log2 of a power of two (0 for 1).
    function automatic int unsigned frac_bits(input int unsigned samples);
        int unsigned w;
        w = 0;
        while ((32'd1 << w) < samples) w++;
        return w;
    endfunction

endpackage

// File: rtl/fta_adder_tree.sv
module fta_adder_tree #(
    parameter int unsigned LANES = 8,
    parameter int unsigned IN_W  = 9,
    parameter int unsigned OUT_W = IN_W + fta_pkg::frac_bits(LANES)
) (
    input  logic [LANES*IN_W-1:0] lanes_i,
    output logic [OUT_W-1:0]      sum_o
);
    localparam int unsigned LEVELS = fta_pkg::frac_bits(LANES);
    localparam int unsigned LEAVES = 1 << LEVELS;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    // Heap-ordered binary tree: node n has children 2n+1 and 2n+2.
    logic [OUT_W-1:0] node [NODES];

    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g < LANES) begin : g_used
            assign node[LEAVES-1+g] = OUT_W'(lanes_i[g*IN_W +: IN_W]);
        end else begin : g_pad
            assign node[LEAVES-1+g] = '0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_add
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign sum_o = node[0];
endmodule

// File: rtl/fta_read_counter.sv
module fta_read_counter #(
    parameter int unsigned READS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int unsigned CNT_W = fta_pkg::bits_for(READS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(READS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = step_i && (cnt_q == LAST_IDX);
endmodule

// File: rtl/fine_time_averager.sv
module fine_time_averager #(
    parameter int unsigned NUM_CHAINS     = 8,
    parameter int unsigned READS_PER_CHAIN = 4,
    parameter int unsigned CODE_W         = 9,
    localparam int unsigned SAMPLES = NUM_CHAINS * READS_PER_CHAIN,
    localparam int unsigned FRAC_W  = fta_pkg::frac_bits(SAMPLES),
    localparam int unsigned AVG_W   = CODE_W + FRAC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit_start_i,
    input  logic                         code_stb_i,
    input  logic [NUM_CHAINS*CODE_W-1:0] fine_codes_i,
    output logic                         busy_o,
    output logic                         avg_valid_o,
    output logic [AVG_W-1:0]             avg_time_o
);
    localparam int unsigned TREE_W = CODE_W + fta_pkg::frac_bits(NUM_CHAINS);

    typedef struct packed {
        logic             busy;
        logic             valid;
        logic [AVG_W-1:0] acc;
        logic [AVG_W-1:0] result;
    } state_t;

    state_t st_d, st_q;

    logic [TREE_W-1:0] strobe_sum;
    logic              accept_start;
    logic              accept_read;
    logic              last_read;
    logic [AVG_W-1:0]  acc_next;

    fta_adder_tree #(
        .LANES (NUM_CHAINS),
        .IN_W  (CODE_W),
        .OUT_W (TREE_W)
    ) u_tree (
        .lanes_i (fine_codes_i),
        .sum_o   (strobe_sum)
    );

    fta_read_counter #(
        .READS (READS_PER_CHAIN)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept_start),
        .step_i  (accept_read),
        .last_o  (last_read)
    );

    assign accept_start = hit_start_i && !st_q.busy;
    assign accept_read  = code_stb_i && st_q.busy;
    assign acc_next     = st_q.acc + AVG_W'(strobe_sum);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (accept_start) begin
            st_d.busy = 1'b1;
            st_d.acc  = '0;
        end
        if (accept_read) begin
            st_d.acc = acc_next;
            if (last_read) begin
                st_d.busy   = 1'b0;
                st_d.valid  = 1'b1;
                st_d.result = acc_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign avg_valid_o = st_q.valid;
    assign avg_time_o  = st_q.result;
endmodule

// File: rtl/fta_checker.sv
module fta_checker #(
    parameter int unsigned SAMPLES = 32,
    parameter int unsigned CODE_W  = 9,
    parameter int unsigned AVG_W   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_start_i,
    input logic             code_stb_i,
    input logic             busy_o,
    input logic             avg_valid_o,
    input logic [AVG_W-1:0] avg_time_o
);
    localparam logic [AVG_W:0] MAX_SUM = (AVG_W+1)'(SAMPLES * ((1 << CODE_W) - 1));

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_start_i && !busy_o) |=> busy_o);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid_o |-> ({1'b0, avg_time_o} <= MAX_SUM));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid_o |=> !avg_valid_o);

    a_r5_valid_closes_hit: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid_o |-> (!busy_o && $past(busy_o)));

    a_r6_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !code_stb_i) |=> busy_o);

    a_r7_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !hit_start_i) |=> (!busy_o && !avg_valid_o));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid_o |-> $stable(avg_time_o));
endmodule

bind fine_time_averager fta_checker #(
    .SAMPLES (SAMPLES),
    .CODE_W  (CODE_W),
    .AVG_W   (AVG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_start_i (hit_start_i),
    .code_stb_i  (code_stb_i),
    .busy_o      (busy_o),
    .avg_valid_o (avg_valid_o),
    .avg_time_o  (avg_time_o)
);

// File: tb/fine_time_averager_tb.sv
module fine_time_averager_tb;
    localparam int M  = 8;
    localparam int N  = 4;
    localparam int CW = 9;
    localparam int S  = M * N;
    localparam int AW = CW + 5;
    localparam int CODE_MAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hs = 1'b0;
    logic            stb = 1'b0;
    logic [M*CW-1:0] codes = '0;
    logic            busy;
    logic            valid;
    logic [AW-1:0]   avg;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fine_time_averager #(
        .NUM_CHAINS      (M),
        .READS_PER_CHAIN (N),
        .CODE_W          (CW)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_start_i  (hs),
        .code_stb_i   (stb),
        .fine_codes_i (codes),
        .busy_o       (busy),
        .avg_valid_o  (valid),
        .avg_time_o   (avg)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference model
    int m_busy = 0, m_valid = 0, m_cnt = 0, m_acc = 0, m_res = 0;

    function automatic int vec_sum(input logic [M*CW-1:0] v);
        int s = 0;
        for (int c = 0; c < M; c++) s += int'(v[c*CW +: CW]);
        return s;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_cnt = 0; m_acc = 0; m_res = 0;
        end else begin
            m_valid = 0;
            if (hs && m_busy == 0) begin
                m_busy = 1; m_acc = 0; m_cnt = 0;
            end else if (stb && m_busy == 1) begin
                m_acc += vec_sum(codes);
                m_cnt++;
                if (m_cnt == N) begin
                    m_busy = 0; m_valid = 1; m_res = m_acc;
                end
            end
        end
    end

    // Per-cycle comparison against the model (R2, R5, R4, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy[0], "R2 busy vs model", busy, m_busy);
            check(valid == m_valid[0], "R5 valid vs model", valid, m_valid);
            check(int'(avg) == m_res, "R4 result vs model", avg, m_res);
        end
    end

    function automatic logic [M*CW-1:0] make_codes(input int mode);
        logic [M*CW-1:0] v;
        for (int c = 0; c < M; c++) begin
            case (mode)
                0: v[c*CW +: CW] = CW'(CODE_MAX);
                1: v[c*CW +: CW] = CW'(c);
                2: v[c*CW +: CW] = CW'(7);
                default: v[c*CW +: CW] = CW'($urandom);
            endcase
        end
        return v;
    endfunction

    // One hit: start pulse, then N strobes with `gap` idle cycles before each.
    // hs_during keeps hit_start high while strobing (R6).
    task automatic run_hit(input int mode, input int gap, input bit hs_during);
        @(negedge clk); hs = 1'b1; stb = 1'b0;
        for (int k = 0; k < N; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); hs = hs_during; stb = 1'b0;
            end
            @(negedge clk); hs = hs_during; stb = 1'b1; codes = make_codes(mode);
        end
        @(negedge clk); hs = 1'b0; stb = 1'b0;
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        check(avg == '0, "R1 result in reset", avg, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && valid == 1'b0 && avg == '0, "R1 first cycle after reset", {busy, valid}, 0);

        // R2: start opens a hit
        @(negedge clk); hs = 1'b1;
        @(negedge clk); hs = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int k = 0; k < N; k++) begin
            stb = 1'b1; codes = make_codes(2);
            @(negedge clk);
        end
        stb = 1'b0;
        // R5: valid one cycle after last strobe, busy dropped
        check(valid == 1'b1 && busy == 1'b0, "R5 valid after last strobe", {valid, busy}, 2);
        check(int'(avg) == 7 * S, "R4 integer mean", avg, 7 * S);
        @(negedge clk);
        check(valid == 1'b0, "R5 valid is one cycle", valid, 0);

        // R3: all codes at maximum
        run_hit(0, 0, 1'b0);
        check(valid == 1'b1, "R3 valid on max codes", valid, 1);
        check(int'(avg) == S * CODE_MAX, "R3 no overflow", avg, S * CODE_MAX);

        // R4: mean with fraction (chain index codes)
        run_hit(1, 0, 1'b0);
        check(int'(avg) == N * M * (M - 1) / 2, "R4 fractional mean", avg, N * M * (M - 1) / 2);

        // R6: start held high during the hit is ignored
        run_hit(2, 0, 1'b1);
        check(valid == 1'b1, "R6 result not delayed", valid, 1);
        check(int'(avg) == 7 * S, "R6 sum not restarted", avg, 7 * S);

        // R7: strobes while idle are ignored
        @(negedge clk); stb = 1'b1; codes = make_codes(0);
        @(negedge clk); stb = 1'b1;
        @(negedge clk); stb = 1'b0;
        check(busy == 1'b0 && valid == 1'b0, "R7 idle strobe no effect", {busy, valid}, 0);
        check(int'(avg) == 7 * S, "R7 result unchanged", avg, 7 * S);

        // R8: result held over idle cycles
        repeat (5) @(negedge clk);
        check(int'(avg) == 7 * S, "R8 result held", avg, 7 * S);

        // R9: gaps between strobes
        run_hit(1, 3, 1'b0);
        check(valid == 1'b1, "R9 valid with gaps", valid, 1);
        check(int'(avg) == N * M * (M - 1) / 2, "R9 sum with gaps", avg, N * M * (M - 1) / 2);

        // Random codes, mixed gaps, checked by the model
        for (int h = 0; h < 40; h++) run_hit(3, h % 3, h[0]);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule